// File: doc/BRIEF.md
# Power-up soft-start sequencer

This block times the start-up of a switching regulator controller from a single reference clock. It watches two asynchronous flags: one says the bias supply is good, the other says the shared compensation/shutdown node sits above its enable threshold. While either flag is low the converter is held quiet. Once both are high, it runs three timed phases. The first is a settling wait. The second forces the compensation node to the reference level to discharge the loop network. The third steps a feedback-offset code from full scale down to zero, so that the output rises smoothly.

The outputs are an oscillator enable, a gate-drive enable, the compensation force strobe, the offset code for an external offset DAC, and a completion flag. Losing either input flag at any moment sends the block back to its quiet state. The full sequence then runs again from the settling wait.

Top module: `softstart_seq`

## Requirements
- R1: Each input flag passes through a two-stage synchronizer. The sequence leaves the quiet state only when both synchronized flags are high. If the flags are set before clock edge 1, `osc_en` rises after edge 3. With only one flag high, the block stays quiet.
- R2: In the quiet state, `osc_en`, `gate_en`, `comp_force` and `seq_done` are 0 and `fb_offset` holds full scale (2047).
- R3: The settling phase lasts 1024 cycles. `osc_en` is 1 throughout, while `gate_en` and `comp_force` are 0 and `fb_offset` stays at 2047.
- R4: Right after settling, `comp_force` is 1 for exactly 24 cycles, with `gate_en` 0.
- R5: After the discharge phase, `gate_en` becomes 1 and `fb_offset` reads 2047 in the first ramp cycle. The code then falls by one per cycle and reads 0 in the 2048th ramp cycle.
- R6: If either input flag falls in any phase, all outputs return to the quiet values 3 edges after the drop. When both flags are high again, the sequence restarts from the settling phase.
- R7: The cycle after the last ramp cycle, `seq_done` becomes 1 with `fb_offset` at 0. `seq_done`, `gate_en` and `osc_en` stay 1 for as long as both flags remain high.
- R8: A high `rst` at a clock edge forces the quiet state and clears the synchronizers. After `rst` falls with both flags high, `osc_en` rises on the third edge.
- R9: When a dropout reaches the state machine on the same edge that would end the ramp, the dropout wins. `seq_done` stays 0 and the quiet state follows.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 1 | Asynchronous supply-good flag from the power-on detector |
| comp_above | input | 1 | Asynchronous flag, compensation/shutdown node above threshold |
| osc_en | output | 1 | Oscillator enable |
| gate_en | output | 1 | Gate-drive enable for both switches |
| comp_force | output | 1 | Force compensation node to reference level |
| fb_offset | output | 11 | Feedback offset code, full scale down to zero |
| seq_done | output | 1 | Start-up sequence complete |

## Verification
The end of the ramp and a shutdown request can land on the same state-machine edge. In that cycle, one request wants to enter the completed state and the other wants to return to quiet. The bench provokes this by dropping the compensation flag exactly three edges before the ramp's terminal edge, counted from the synchronizer latency. It judges the result by requiring the last ramp code of 0 to appear first, followed by a quiet state with `seq_done` never raised. A second coincidence is also exercised: a dropout that arrives in the middle of the discharge phase must end the force strobe at once instead of letting it finish its 24 cycles.

// File: rtl/ss_pkg.sv
package ss_pkg;

  // Start-up phases of the sequencer
  typedef enum logic [2:0] {
    PH_IDLE   = 3'd0,
    PH_SETTLE = 3'd1,
    PH_DISCH  = 3'd2,
    PH_RAMP   = 3'd3,
    PH_DONE   = 3'd4
  } phase_t;

  function automatic int unsigned max3(input int unsigned a,
                                       input int unsigned b,
                                       input int unsigned c);
    int unsigned m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // One shift chain per asynchronous flag
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], d[b]};
      end
    end

    assign q[b] = chain[STAGES-1];
  end

endmodule

// File: rtl/ss_phase_counter.sv
module ss_phase_counter #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  output logic [CNT_W-1:0] cnt
);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt <= '0;
    end else if (en) begin
      cnt <= cnt + 1'b1;
    end
  end

  // The count never wraps inside a phase; the terminal compare must catch it first
  AST_CNT_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (en && !clr && (cnt == {CNT_W{1'b1}})) |=> (cnt == {CNT_W{1'b1}})) // R5
    else $error("phase counter wrapped");

endmodule

// File: rtl/ss_fsm.sv
module ss_fsm
  import ss_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int DISCH_CYCLES  = 24,
  parameter int RAMP_CYCLES   = 2048,
  parameter int CNT_W         = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_ok,
  input  logic [CNT_W-1:0] cnt,
  output phase_t           phase,
  output phase_t           nphase,
  output logic             cnt_clr,
  output logic             cnt_en,
  output logic             osc_en,
  output logic             gate_en,
  output logic             comp_force,
  output logic             seq_done
);

  localparam logic [CNT_W-1:0] SETTLE_LAST = CNT_W'(SETTLE_CYCLES - 1);
  localparam logic [CNT_W-1:0] DISCH_LAST  = CNT_W'(DISCH_CYCLES - 1);
  localparam logic [CNT_W-1:0] RAMP_LAST   = CNT_W'(RAMP_CYCLES - 1);

  // Next-phase decision; a dropout takes priority over every transition
  always_comb begin
    nphase = phase;
    if (!run_ok) begin
      nphase = PH_IDLE;
    end else begin
      case (phase)
        PH_IDLE:   nphase = PH_SETTLE;
        PH_SETTLE: if (cnt == SETTLE_LAST) nphase = PH_DISCH;
        PH_DISCH:  if (cnt == DISCH_LAST)  nphase = PH_RAMP;
        PH_RAMP:   if (cnt == RAMP_LAST)   nphase = PH_DONE;
        PH_DONE:   nphase = PH_DONE;
        default:   nphase = PH_IDLE;
      endcase
    end
    cnt_clr = (nphase != phase);
    cnt_en  = (phase == PH_SETTLE) || (phase == PH_DISCH) || (phase == PH_RAMP);
  end

  // Phase and outputs registered together from the next phase
  always_ff @(posedge clk) begin
    if (rst) begin
      phase      <= PH_IDLE;
      osc_en     <= 1'b0;
      gate_en    <= 1'b0;
      comp_force <= 1'b0;
      seq_done   <= 1'b0;
    end else begin
      phase      <= nphase;
      osc_en     <= (nphase != PH_IDLE);
      gate_en    <= (nphase == PH_RAMP) || (nphase == PH_DONE);
      comp_force <= (nphase == PH_DISCH);
      seq_done   <= (nphase == PH_DONE);
    end
  end

  AST_DROP_TO_IDLE: assert property (@(posedge clk) disable iff (rst)
    !run_ok |=> (phase == PH_IDLE) && !osc_en && !gate_en) // R6
    else $error("dropout did not return to idle");

  AST_SETTLE_LEN: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DISCH) && ($past(phase) == PH_SETTLE)) |-> ($past(cnt) == SETTLE_LAST)) // R3
    else $error("settle phase length wrong");

  AST_DISCH_LEN: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RAMP) && ($past(phase) == PH_DISCH)) |-> ($past(cnt) == DISCH_LAST)) // R4
    else $error("discharge phase length wrong");

  AST_RAMP_LEN: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_DONE) && ($past(phase) == PH_RAMP)) |-> ($past(cnt) == RAMP_LAST)) // R5
    else $error("ramp phase length wrong");

  AST_FORCE_NO_GATE: assert property (@(posedge clk) disable iff (rst)
    comp_force |-> (!gate_en && osc_en)) // R4
    else $error("force strobe overlaps gate drive");

  AST_GATE_NEEDS_OSC: assert property (@(posedge clk) disable iff (rst)
    gate_en |-> osc_en) // R5
    else $error("gate drive without oscillator");

  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (seq_done && run_ok) |=> seq_done) // R7
    else $error("done flag dropped while running");

endmodule

// File: rtl/ss_offset_ramp.sv
module ss_offset_ramp
  import ss_pkg::*;
#(
  parameter int OFFSET_W = 11
) (
  input  logic                clk,
  input  logic                rst,
  input  phase_t              phase,
  input  phase_t              nphase,
  output logic [OFFSET_W-1:0] offset
);

  localparam logic [OFFSET_W-1:0] FULL = {OFFSET_W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst) begin
      offset <= FULL;
    end else begin
      case (nphase)
        PH_RAMP: offset <= (phase == PH_RAMP) ? (offset - 1'b1) : FULL;
        PH_DONE: offset <= '0;
        default: offset <= FULL;
      endcase
    end
  end

  AST_RAMP_STEP: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RAMP) && ($past(phase) == PH_RAMP)) |-> (offset == $past(offset) - OFFSET_W'(1))) // R5
    else $error("offset did not step by one");

  AST_RAMP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_RAMP) && ($past(phase) != PH_RAMP)) |-> (offset == FULL)) // R5
    else $error("ramp did not start at full scale");

  AST_DONE_ZERO: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_DONE) |-> (offset == '0)) // R7
    else $error("offset not zero when done");

  AST_IDLE_FULL: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_IDLE) |-> (offset == FULL)) // R2
    else $error("offset not full scale in idle");

endmodule

// File: rtl/softstart_seq.sv
module softstart_seq
  import ss_pkg::*;
#(
  parameter int SETTLE_CYCLES = 1024,
  parameter int DISCH_CYCLES  = 24,
  parameter int OFFSET_W      = 11,
  parameter int SYNC_STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                supply_ok,
  input  logic                comp_above,
  output logic                osc_en,
  output logic                gate_en,
  output logic                comp_force,
  output logic [OFFSET_W-1:0] fb_offset,
  output logic                seq_done
);

  localparam int RAMP_CYCLES = 2 ** OFFSET_W;
  localparam int PH_MAX      = max3(SETTLE_CYCLES, DISCH_CYCLES, RAMP_CYCLES);
  localparam int CNT_W       = (PH_MAX > 2) ? $clog2(PH_MAX) : 1;

  logic [1:0]       flags_sync;
  logic             run_ok;
  logic [CNT_W-1:0] cnt;
  logic             cnt_clr;
  logic             cnt_en;
  phase_t           phase;
  phase_t           nphase;

  ss_sync #(
    .WIDTH  (2),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({comp_above, supply_ok}),
    .q   (flags_sync)
  );

  assign run_ok = flags_sync[0] & flags_sync[1];

  ss_phase_counter #(
    .CNT_W (CNT_W)
  ) u_cnt (
    .clk (clk),
    .rst (rst),
    .clr (cnt_clr),
    .en  (cnt_en),
    .cnt (cnt)
  );

  ss_fsm #(
    .SETTLE_CYCLES (SETTLE_CYCLES),
    .DISCH_CYCLES  (DISCH_CYCLES),
    .RAMP_CYCLES   (RAMP_CYCLES),
    .CNT_W         (CNT_W)
  ) u_fsm (
    .clk        (clk),
    .rst        (rst),
    .run_ok     (run_ok),
    .cnt        (cnt),
    .phase      (phase),
    .nphase     (nphase),
    .cnt_clr    (cnt_clr),
    .cnt_en     (cnt_en),
    .osc_en     (osc_en),
    .gate_en    (gate_en),
    .comp_force (comp_force),
    .seq_done   (seq_done)
  );

  ss_offset_ramp #(
    .OFFSET_W (OFFSET_W)
  ) u_ramp (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .nphase (nphase),
    .offset (fb_offset)
  );

  AST_QUIET_OUTPUTS: assert property (@(posedge clk) disable iff (rst)
    !osc_en |-> (!gate_en && !comp_force && !seq_done && (fb_offset == {OFFSET_W{1'b1}}))) // R2
    else $error("outputs active while oscillator stopped");

endmodule

// File: tb/softstart_seq_test.sv
module softstart_seq_test;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 11;

  // Expected vectors: edge count since both flags were set, and
  // {osc_en, gate_en, comp_force, seq_done, fb_offset[10:0]}
  localparam int TAB_EDGE [NV] = '{2, 3, 1026, 1027, 1050, 1051, 1052, 2075, 3098, 3099, 3200};
  localparam logic [14:0] TAB_EXP [NV] = '{
    {4'b0000, 11'd2047},  // R1 not yet out of idle
    {4'b1000, 11'd2047},  // R3 settle begins
    {4'b1000, 11'd2047},  // R3 last settle cycle
    {4'b1010, 11'd2047},  // R4 force begins
    {4'b1010, 11'd2047},  // R4 last force cycle
    {4'b1100, 11'd2047},  // R5 ramp first cycle
    {4'b1100, 11'd2046},  // R5 second step
    {4'b1100, 11'd1023},  // R5 mid ramp
    {4'b1100, 11'd0},     // R5 last ramp cycle
    {4'b1101, 11'd0},     // R7 done
    {4'b1101, 11'd0}      // R7 held
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        supply_ok = 1'b0;
  logic        comp_above = 1'b0;
  logic        osc_en, gate_en, comp_force, seq_done;
  logic [10:0] fb_offset;

  int n_checks = 0;
  int n_fail   = 0;
  int cur      = 0;

  softstart_seq uut (
    .clk        (clk),
    .rst        (rst),
    .supply_ok  (supply_ok),
    .comp_above (comp_above),
    .osc_en     (osc_en),
    .gate_en    (gate_en),
    .comp_force (comp_force),
    .fb_offset  (fb_offset),
    .seq_done   (seq_done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Advance n rising edges and sample a quarter period after the last one
  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #(CLK_PERIOD/4);
    cur += n;
  endtask

  task automatic goto_edge(input int e);
    step(e - cur);
  endtask

  task automatic check(input string req, input logic [14:0] exp);
    logic [14:0] act;
    act = {osc_en, gate_en, comp_force, seq_done, fb_offset};
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at t=%0t: actual osc/gate/force/done=%b offset=%0d, expected %b offset=%0d",
               req, $time, act[14:11], act[10:0], exp[14:11], exp[10:0]);
    end
  endtask

  localparam logic [14:0] QUIET = {4'b0000, 11'd2047};

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    // R8 / R2: reset state
    step(3);
    check("R8", QUIET);
    rst = 1'b0;
    step(5);
    check("R2", QUIET);

    // R1: one flag alone never starts the sequence
    supply_ok = 1'b1;
    step(40);
    check("R1", QUIET);
    supply_ok = 1'b0;
    comp_above = 1'b1;
    step(40);
    check("R1", QUIET);

    // Main vector walk: full sequence
    supply_ok = 1'b1;
    cur = 0;
    for (int i = 0; i < NV; i++) begin
      goto_edge(TAB_EDGE[i]);
      check((i < 2) ? "R1" : (i < 3) ? "R3" : (i < 5) ? "R4" : (i < 9) ? "R5" : "R7", TAB_EXP[i]);
    end

    // R6: dropout from done, latency three edges, then restart
    comp_above = 1'b0;
    cur = 0;
    step(2);
    check("R6", {4'b1101, 11'd0});
    step(1);
    check("R6", QUIET);
    step(10);
    comp_above = 1'b1;
    cur = 0;
    goto_edge(3);
    check("R6", {4'b1000, 11'd2047});
    goto_edge(1026);
    check("R6", {4'b1000, 11'd2047});
    goto_edge(1030);
    check("R6", {4'b1010, 11'd2047});
    // R6: supply drops mid-discharge, force strobe cut short
    supply_ok = 1'b0;
    goto_edge(1032);
    check("R6", {4'b1010, 11'd2047});
    goto_edge(1033);
    check("R6", QUIET);

    // R6: dropout mid-ramp
    supply_ok = 1'b1;
    cur = 0;
    goto_edge(2000);
    check("R6", {4'b1100, 11'(2047 - (2000 - 1051))});
    comp_above = 1'b0;
    goto_edge(2002);
    check("R6", {4'b1100, 11'(2047 - (2002 - 1051))});
    goto_edge(2003);
    check("R6", QUIET);

    // R9: dropout reaches the state machine on the ramp's terminal edge
    step(5);
    comp_above = 1'b1;
    cur = 0;
    goto_edge(3096);
    comp_above = 1'b0;
    goto_edge(3098);
    check("R9", {4'b1100, 11'd0});
    goto_edge(3099);
    check("R9", QUIET);
    goto_edge(3120);
    check("R9", QUIET);

    // R8: synchronous reset mid-sequence, then restart latency
    comp_above = 1'b1;
    cur = 0;
    goto_edge(500);
    check("R8", {4'b1000, 11'd2047});
    rst = 1'b1;
    step(1);
    check("R8", QUIET);
    rst = 1'b0;
    cur = 0;
    goto_edge(2);
    check("R8", QUIET);
    goto_edge(3);
    check("R8", {4'b1000, 11'd2047});

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule